// File: doc/BRIEF.md
# CAN Bus-Off Recovery Monitor

This block decides when a CAN node may come back from the bus-off state. A pulse from the error-confinement logic puts the node into bus-off. While the node is in that state, the block watches the sampled receive bit on each bit-sample strobe. How the node leaves bus-off depends on a restart-policy bit held in a small configuration register.

With automatic restart selected, the block counts runs of eleven consecutive recessive bits. After the 128th complete run, it leaves bus-off. With manual restart selected, which is the value after reset, the bus activity is not counted. The node stays in bus-off until software asserts a restart request. In both cases, leaving bus-off raises a one-cycle recovery pulse. Logic elsewhere uses this pulse to clear the transmit and receive error counters.

Top module: `busoff_recovery_monitor`

## Requirements
- R1: During and after synchronous reset, `bus_off` and `recovered` are both 0.
- R2: A restart-policy register is loaded from `cfg_auto_in` in any cycle with `cfg_we` high (0 = manual restart, 1 = automatic restart). Its reset value is 0, so manual restart is in force until it is written.
- R3: A high `busoff_enter` at a clock edge makes `bus_off` read 1 after that edge. `bus_off` never rises without it.
- R4: In automatic mode during bus-off, only cycles with `rx_strobe` high count. In those cycles `rx_bit` = 1 means recessive and 0 means dominant. Eleven recessive strobes in a row complete one group. Changes on `rx_bit` without a strobe have no effect.
- R5: A strobed dominant bit clears the current run of recessive bits. The number of groups already completed is kept.
- R6: In automatic mode, `bus_off` falls at the clock edge that samples the strobe completing the 128th group, and not earlier.
- R7: In manual mode, recessive runs never end bus-off. A `restart_req` sampled during bus-off ends it at that edge. A `restart_req` is ignored when automatic mode is selected or when the node is not in bus-off.
- R8: Leaving bus-off gives a `recovered` pulse exactly one cycle long, in the same cycle that `bus_off` falls. Both counters are cleared, so the next bus-off again needs the full 128 groups.
- R9: A `busoff_enter` pulse during bus-off restarts counting from zero. If it arrives in the same cycle as an exit condition, it has priority and the node stays in bus-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the restart-policy register |
| cfg_auto_in | input | 1 | Restart policy to load: 1 automatic, 0 manual |
| busoff_enter | input | 1 | One-cycle pulse: the error logic has entered bus-off |
| rx_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| rx_strobe | input | 1 | Marks the cycle in which `rx_bit` is a valid sample |
| restart_req | input | 1 | Software restart request for manual mode |
| bus_off | output | 1 | Node is in bus-off |
| recovered | output | 1 | One-cycle pulse on leaving bus-off |

## Verification
The checker evaluates the following rules on every cycle:
- Entry always sets the flag.
- The flag never rises by itself.
- The recovery pulse is one cycle long and coincides with the falling flag.
- No exit happens in manual mode without a request.
- No exit happens in automatic mode on a cycle with no strobe or with a dominant sample.
- The policy register changes only when written.

Some properties are only shown by the bench scenarios, because they depend on exact counts over long stretches:
- The exit lands on exactly the 1408th qualifying recessive strobe.
- A dominant bit costs only the partial run.
- Unstrobed bit changes are ignored.
- Re-entry and entry/exit collisions restart the full count.

// File: rtl/busoff_pkg.sv
package busoff_pkg;

  typedef enum logic {
    ST_ONLINE = 1'b0,
    ST_BUSOFF = 1'b1
  } link_state_t;

  // Width of a counter that holds 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/busoff_run_counter.sv
// Counts consecutive recessive samples; flags completion of one run.
module busoff_run_counter #(
  parameter int RUN_LEN = 11,
  localparam int W = busoff_pkg::cnt_width(RUN_LEN)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         recessive,
  output logic         run_done
);

  logic [W-1:0] run_cnt;
  localparam logic [W-1:0] LAST = W'(RUN_LEN - 1);

  assign run_done = en && recessive && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_cnt <= '0;
    end else if (en) begin
      if (!recessive || run_done) run_cnt <= '0;
      else                        run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/busoff_group_counter.sv
// Counts completed recessive runs; flags the final one.
module busoff_group_counter #(
  parameter int GROUP_TOTAL = 128,
  localparam int W = busoff_pkg::cnt_width(GROUP_TOTAL)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic grp_last
);

  logic [W-1:0] grp_cnt;
  localparam logic [W-1:0] LAST = W'(GROUP_TOTAL - 1);

  assign grp_last = inc && (grp_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      grp_cnt <= '0;
    end else if (inc) begin
      if (grp_last) grp_cnt <= '0;
      else          grp_cnt <= grp_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/busoff_ctrl.sv
// Policy register, bus-off state and recovery pulse.
module busoff_ctrl
  import busoff_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_auto_in,
  input  logic enter,
  input  logic restart_req,
  input  logic rx_strobe,
  input  logic grp_last,
  output logic cfg_auto,
  output logic bus_off,
  output logic recovered,
  output logic count_en,
  output logic cnt_clr
);

  link_state_t state_q;
  logic        auto_q;
  logic        pulse_q;
  logic        in_busoff;
  logic        exit_now;

  assign in_busoff = (state_q == ST_BUSOFF);
  assign count_en  = in_busoff && auto_q && rx_strobe && !enter;
  assign exit_now  = in_busoff && !enter && (auto_q ? grp_last : restart_req);
  assign cnt_clr   = enter || exit_now || !in_busoff || !auto_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ONLINE;
      auto_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (cfg_we) auto_q <= cfg_auto_in;
      if (enter)         state_q <= ST_BUSOFF;
      else if (exit_now) state_q <= ST_ONLINE;
      pulse_q <= exit_now;
    end
  end

  assign cfg_auto  = auto_q;
  assign bus_off   = in_busoff;
  assign recovered = pulse_q;

endmodule

// File: rtl/busoff_recovery_monitor.sv
module busoff_recovery_monitor #(
  parameter int RUN_LEN     = 11,
  parameter int GROUP_TOTAL = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_auto_in,
  input  logic busoff_enter,
  input  logic rx_bit,
  input  logic rx_strobe,
  input  logic restart_req,
  output logic bus_off,
  output logic recovered
);

  logic cfg_auto_q;
  logic count_en;
  logic cnt_clr;
  logic run_done;
  logic grp_last;

  busoff_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_auto_in (cfg_auto_in),
    .enter       (busoff_enter),
    .restart_req (restart_req),
    .rx_strobe   (rx_strobe),
    .grp_last    (grp_last),
    .cfg_auto    (cfg_auto_q),
    .bus_off     (bus_off),
    .recovered   (recovered),
    .count_en    (count_en),
    .cnt_clr     (cnt_clr)
  );

  busoff_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst       (rst),
    .clr       (cnt_clr),
    .en        (count_en),
    .recessive (rx_bit),
    .run_done  (run_done)
  );

  busoff_group_counter #(.GROUP_TOTAL(GROUP_TOTAL)) u_grp (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .inc      (run_done),
    .grp_last (grp_last)
  );

endmodule

// File: rtl/busoff_monitor_checker.sv
module busoff_monitor_checker (
  input logic clk,
  input logic rst,
  input logic cfg_we,
  input logic busoff_enter,
  input logic rx_bit,
  input logic rx_strobe,
  input logic restart_req,
  input logic auto_mode,
  input logic bus_off,
  input logic recovered
);

  AST_ENTRY_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    busoff_enter |=> bus_off); // R3
  AST_FLAG_RISES_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_off) |-> $past(busoff_enter)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    recovered |=> !recovered); // R8
  AST_PULSE_WITH_FALL: assert property (@(posedge clk) disable iff (rst)
    recovered |-> $fell(bus_off)); // R8
  AST_FALL_GIVES_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_off) |-> recovered); // R8
  AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (bus_off && !auto_mode && !restart_req) |=> bus_off); // R7
  AST_ONLINE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !bus_off |=> !recovered); // R7
  AST_AUTO_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bus_off && auto_mode && !rx_strobe) |=> bus_off); // R4
  AST_DOMINANT_NO_EXIT: assert property (@(posedge clk) disable iff (rst)
    (bus_off && auto_mode && rx_strobe && !rx_bit) |=> bus_off); // R5
  AST_POLICY_HELD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(auto_mode)); // R2

endmodule

bind busoff_recovery_monitor busoff_monitor_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .busoff_enter (busoff_enter),
  .rx_bit       (rx_bit),
  .rx_strobe    (rx_strobe),
  .restart_req  (restart_req),
  .auto_mode    (cfg_auto_q),
  .bus_off      (bus_off),
  .recovered    (recovered)
);

// File: tb/test_busoff_recovery_monitor.sv
module test_busoff_recovery_monitor;

  localparam int RUN_LEN     = 11;
  localparam int GROUP_TOTAL = 128;
  localparam int FULL        = RUN_LEN * GROUP_TOTAL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_auto_in = 1'b0, busoff_enter = 1'b0;
  logic rx_bit = 1'b1, rx_strobe = 1'b0, restart_req = 1'b0;
  logic bus_off, recovered;

  typedef struct { int at; string tag; } exp_t;
  exp_t sb_q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  busoff_recovery_monitor #(.RUN_LEN(RUN_LEN), .GROUP_TOTAL(GROUP_TOTAL)) i_busoff_recovery_monitor (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_auto_in(cfg_auto_in),
    .busoff_enter(busoff_enter), .rx_bit(rx_bit), .rx_strobe(rx_strobe),
    .restart_req(restart_req), .bus_off(bus_off), .recovered(recovered)
  );

  // Monitor: every recovery pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && recovered) begin
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6 unexpected recovery pulse at cycle %0d: actual=1 expected=0", cyc);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.at != cyc) begin
          n_bad++;
          $display("FAIL %s recovery pulse cycle: actual=%0d expected=%0d", e.tag, cyc, e.at);
        end
      end
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic enter_busoff();
    busoff_enter = 1'b1; tick(); busoff_enter = 1'b0;
  endtask

  task automatic set_mode(logic a);
    cfg_we = 1'b1; cfg_auto_in = a; tick(); cfg_we = 1'b0;
  endtask

  task automatic send_bit(logic b, bit expect_exit, string tag);
    if (expect_exit) sb_q.push_back('{cyc + 1, tag});
    rx_bit = b; rx_strobe = 1'b1; tick();
    rx_strobe = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic send_run(int n, logic b, bit exit_on_last, string tag);
    for (int i = 0; i < n; i++) send_bit(b, exit_on_last && (i == n - 1), tag);
  endtask

  task automatic request_restart(bit expect_exit, string tag);
    if (expect_exit) sb_q.push_back('{cyc + 1, tag});
    restart_req = 1'b1; tick(); restart_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1", bus_off, 1'b0, "bus_off in reset");
    check("R1", recovered, 1'b0, "recovered in reset");
    rst = 1'b0;
    tick();
    check("R1", bus_off, 1'b0, "bus_off after reset");

    // Manual mode by default: recessive bits do not end bus-off
    enter_busoff();
    check("R3", bus_off, 1'b1, "bus_off after entry");
    send_run(FULL + 20, 1'b1, 0, "R2");
    check("R2", bus_off, 1'b1, "manual default ignores recessive runs");
    request_restart(1, "R7");
    check("R8", bus_off, 1'b0, "bus_off cleared by restart");
    tick();
    check("R8", recovered, 1'b0, "pulse lasts one cycle");

    // Restart request while online: no effect
    request_restart(0, "R7");
    check("R7", recovered, 1'b0, "restart while online");
    check("R7", bus_off, 1'b0, "flag while online");

    // Automatic mode, exact count
    set_mode(1'b1);
    enter_busoff();
    send_run(FULL - 1, 1'b1, 0, "R6");
    check("R6", bus_off, 1'b1, "one bit before final group");
    send_bit(1'b1, 1, "R6");
    check("R6", bus_off, 1'b0, "left bus-off on final group");
    tick();
    check("R8", recovered, 1'b0, "pulse lasts one cycle (auto)");

    // Counters restart from zero; unstrobed dominant ignored
    enter_busoff();
    send_run(5 * RUN_LEN + RUN_LEN - 1, 1'b1, 0, "R4");
    rx_bit = 1'b0; repeat (3) tick(); rx_bit = 1'b1;
    send_bit(1'b1, 0, "R4");
    send_run((GROUP_TOTAL - 6) * RUN_LEN - 1, 1'b1, 0, "R4");
    check("R4", bus_off, 1'b1, "still bus-off before last strobe");
    send_bit(1'b1, 1, "R4");

    // Strobed dominant clears only the partial run; restart ignored in auto
    enter_busoff();
    send_run(5 * RUN_LEN + RUN_LEN - 1, 1'b1, 0, "R5");
    send_bit(1'b0, 0, "R5");
    request_restart(0, "R7");
    check("R7", bus_off, 1'b1, "restart ignored in auto mode");
    send_run((GROUP_TOTAL - 5) * RUN_LEN - 1, 1'b1, 0, "R5");
    check("R5", bus_off, 1'b1, "dominant cost the partial run");
    send_bit(1'b1, 1, "R5");

    // Re-entry restarts the count
    enter_busoff();
    send_run(60 * RUN_LEN + 3, 1'b1, 0, "R9");
    enter_busoff();
    send_run(FULL - 1, 1'b1, 0, "R9");
    check("R9", bus_off, 1'b1, "count restarted by re-entry");
    send_bit(1'b1, 1, "R9");

    // Entry collides with final strobe: entry wins
    enter_busoff();
    send_run(FULL - 1, 1'b1, 0, "R9");
    busoff_enter = 1'b1; rx_bit = 1'b1; rx_strobe = 1'b1;
    tick();
    busoff_enter = 1'b0; rx_strobe = 1'b0;
    check("R9", bus_off, 1'b1, "entry beats exit");
    check("R9", recovered, 1'b0, "no pulse on collision");
    send_run(FULL, 1'b1, 1, "R9");

    // Back to manual mode
    set_mode(1'b0);
    enter_busoff();
    send_run(FULL, 1'b1, 0, "R2");
    check("R2", bus_off, 1'b1, "manual mode after rewrite");
    request_restart(1, "R7");

    repeat (3) tick();
    n_cmp++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6 missing recovery pulses: actual=%0d expected=0", sb_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule